// File: doc/BRIEF.md
# Four-State Register Transfer Sequencer

This block pairs a small state machine with a register B, which is 3 bits wide by default. In every clock cycle the current state picks one of four transfers for B:
- a parallel load from the input word;
- a shift toward the most significant bit;
- a mixed update built from XOR and AND of neighbouring bits;
- a shift toward the least significant bit.

It shows how a design splits into a controller and a datapath. The controller owns only the two state bits. The datapath has one D flip-flop per bit of B. Each flip-flop is fed by a four-input multiplexer, and the state bits drive the multiplexer select directly.

The caller drives a word `x_in` and a decision bit `a_in`. It watches the register and the state on `b_q` and `st_q`. The state leaves the load state under control of `a_in`. The state leaves the shift-up state under control of bit 0 of `x_in`. Both other states always return to the load state. There is no stream traffic, so every pin is a plain level signal sampled at the rising clock edge.

Top module: `rt4_seq_top`

## Requirements
- R1: When `rst` is high at a rising edge, the next values are `st_q` = 0 and `b_q` = 0, whatever the other inputs are.
- R2: With `st_q` = 0 (code 00), the next value of `b_q` equals `x_in`, bit for bit.
- R3: With `st_q` = 1 (code 01), the next value of `b_q` is the old value shifted one place toward the MSB, with 0 entering bit 0.
- R4: With `st_q` = 2 (code 10), each new bit i below the top is old bit i XOR old bit i+1. The new top bit is the AND of all old bits.
- R5: With `st_q` = 3 (code 11), the next value of `b_q` is the old value shifted one place toward the LSB, with 0 entering the top bit.
- R6: From state 00, the next state is 01 when `a_in` is 1 and 10 when `a_in` is 0.
- R7: From state 01, the next state is 11 when `x_in[0]` is 1 and 10 when `x_in[0]` is 0. `a_in` has no effect in this state.
- R8: From states 10 and 11, the next state is 00, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| x_in | input | W (3) | Parallel load word; bit 0 also steers the exit from state 01 |
| a_in | input | 1 | Decision bit for the exit from state 00 |
| b_q | output | W (3) | Register B |
| st_q | output | 2 | State code: 00 load, 01 shift up, 10 mixed, 11 shift down |

## Verification
A wrong next state shows on `st_q` at the very next edge. It also shows one edge later on `b_q`, because `b_q` then follows a transfer that does not match the expected state. A wrong multiplexer leg or a miswired neighbour bit corrupts `b_q` in the same cycle that the state is used. Comparing both outputs after every edge against a bench model therefore finds any fault within one to two cycles. The input sweep reaches all four states with both values of each decision bit.

// File: rtl/rt4_pkg.sv
package rt4_pkg;
  typedef enum logic [1:0] {
    ST_LOAD = 2'b00,
    ST_SHUP = 2'b01,
    ST_MIX  = 2'b10,
    ST_SHDN = 2'b11
  } rt4_state_e;
endpackage

// File: rtl/rt4_mux4.sv
module rt4_mux4 (
  input  logic [1:0] sel,
  input  logic       d0,
  input  logic       d1,
  input  logic       d2,
  input  logic       d3,
  output logic       y
);
  always_comb begin
    unique case (sel)
      2'd0:    y = d0;
      2'd1:    y = d1;
      2'd2:    y = d2;
      default: y = d3;
    endcase
  end
endmodule

// File: rtl/rt4_ctrl.sv
module rt4_ctrl
  import rt4_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       a_dec,
  input  logic       x0_dec,
  output rt4_state_e state
);
  rt4_state_e nxt;

  always_comb begin
    unique case (state)
      ST_LOAD: nxt = a_dec  ? ST_SHUP : ST_MIX;
      ST_SHUP: nxt = x0_dec ? ST_SHDN : ST_MIX;
      default: nxt = ST_LOAD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_LOAD;
    else     state <= nxt;
  end
endmodule

// File: rtl/rt4_dpath.sv
module rt4_dpath #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   sel,
  input  logic [W-1:0] ld,
  output logic [W-1:0] q
);
  localparam int TOP = W - 1;

  logic [W-1:0] d;
  logic         all_ones;

  assign all_ones = &q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic up_leg, mix_leg, dn_leg;

    if (i == 0) begin : g_lo
      assign up_leg = 1'b0;
    end else begin : g_lo
      assign up_leg = q[i-1];
    end

    if (i == TOP) begin : g_hi
      assign mix_leg = all_ones;
      assign dn_leg  = 1'b0;
    end else begin : g_hi
      assign mix_leg = q[i] ^ q[i+1];
      assign dn_leg  = q[i+1];
    end

    rt4_mux4 u_mux (
      .sel (sel),
      .d0  (ld[i]),
      .d1  (up_leg),
      .d2  (mix_leg),
      .d3  (dn_leg),
      .y   (d[i])
    );

    always_ff @(posedge clk) begin
      if (rst) q[i] <= 1'b0;
      else     q[i] <= d[i];
    end
  end
endmodule

// File: rtl/rt4_seq_top.sv
module rt4_seq_top
  import rt4_pkg::*;
#(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] x_in,
  input  logic         a_in,
  output logic [W-1:0] b_q,
  output logic [1:0]   st_q
);
  rt4_state_e state;

  rt4_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .a_dec  (a_in),
    .x0_dec (x_in[0]),
    .state  (state)
  );

  rt4_dpath #(.W(W)) u_dp (
    .clk (clk),
    .rst (rst),
    .sel (state),
    .ld  (x_in),
    .q   (b_q)
  );

  assign st_q = state;
endmodule

// File: rtl/rt4_seq_chk.sv
module rt4_seq_chk #(
  parameter int W = 3
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] x_in,
  input logic         a_in,
  input logic [W-1:0] b_q,
  input logic [1:0]   st_q
);
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (st_q == 2'd0 && b_q == '0));

  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    st_q == 2'd0 |=> b_q == $past(x_in));

  p_shift_up_r3: assert property (@(posedge clk) disable iff (rst)
    st_q == 2'd1 |=> b_q == {$past(b_q[W-2:0]), 1'b0});

  p_mix_top_r4: assert property (@(posedge clk) disable iff (rst)
    st_q == 2'd2 |=> b_q[W-1] == (&$past(b_q)));

  for (genvar i = 0; i < W - 1; i++) begin : g_mix
    p_mix_low_r4: assert property (@(posedge clk) disable iff (rst)
      st_q == 2'd2 |=> b_q[i] == ($past(b_q[i]) ^ $past(b_q[i+1])));
  end

  p_shift_dn_r5: assert property (@(posedge clk) disable iff (rst)
    st_q == 2'd3 |=> b_q == {1'b0, $past(b_q[W-1:1])});

  p_exit_load_r6: assert property (@(posedge clk) disable iff (rst)
    st_q == 2'd0 |=> st_q == ($past(a_in) ? 2'd1 : 2'd2));

  p_exit_shup_r7: assert property (@(posedge clk) disable iff (rst)
    st_q == 2'd1 |=> st_q == ($past(x_in[0]) ? 2'd3 : 2'd2));

  p_return_r8: assert property (@(posedge clk) disable iff (rst)
    st_q[1] |=> st_q == 2'd0);
endmodule

bind rt4_seq_top rt4_seq_chk #(.W(W)) u_chk (
  .clk  (clk),
  .rst  (rst),
  .x_in (x_in),
  .a_in (a_in),
  .b_q  (b_q),
  .st_q (st_q)
);

// File: tb/sim_rt4_seq_top.sv
`timescale 1ns/1ps
module sim_rt4_seq_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] x_in = 3'd0;
  logic       a_in = 1'b0;
  logic [2:0] b_q;
  logic [1:0] st_q;

  int n_vec  = 0;
  int n_miss = 0;
  bit done   = 1'b0;

  logic [2:0] eb;
  logic [1:0] es;
  logic [1:0] prev_s;
  bit         prev_rst;

  always #10 clk = ~clk;

  rt4_seq_top u0 (
    .clk  (clk),
    .rst  (rst),
    .x_in (x_in),
    .a_in (a_in),
    .b_q  (b_q),
    .st_q (st_q)
  );

  function automatic string b_tag(input bit r, input logic [1:0] s);
    if (r) return "R1";
    case (s)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  function automatic string s_tag(input bit r, input logic [1:0] s);
    if (r) return "R1";
    case (s)
      2'd0: return "R6";
      2'd1: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic compare();
    n_vec++;
    if (b_q !== eb) begin
      n_miss++;
      $display("FAIL %s b_q=%0d expected=%0d", b_tag(prev_rst, prev_s), b_q, eb);
    end
    n_vec++;
    if (st_q !== es) begin
      n_miss++;
      $display("FAIL %s st_q=%0d expected=%0d", s_tag(prev_rst, prev_s), st_q, es);
    end
  endtask

  task automatic advance();
    logic [2:0] nb;
    logic [1:0] ns;
    prev_s   = es;
    prev_rst = rst;
    if (rst) begin
      nb = 3'd0;
      ns = 2'd0;
    end else begin
      case (es)
        2'd0: begin nb = x_in;                                   ns = a_in ? 2'd1 : 2'd2;    end
        2'd1: begin nb = (eb << 1) & 3'd7;                       ns = x_in[0] ? 2'd3 : 2'd2; end
        2'd2: begin nb = {&eb, eb[2] ^ eb[1], eb[1] ^ eb[0]};    ns = 2'd0;                  end
        default: begin nb = eb >> 1;                             ns = 2'd0;                  end
      endcase
    end
    eb = nb;
    es = ns;
  endtask

  initial begin
    eb = 3'd0; es = 2'd0; prev_s = 2'd0; prev_rst = 1'b1;
    // Reset with nonzero inputs: R1
    x_in = 3'd7; a_in = 1'b1; rst = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      advance();
      @(negedge clk);
      compare();
    end
    for (int n = 0; n < 4000; n++) begin
      int v;
      v = (n * 7 + (n >> 5) + (n >> 9) * 3) & 31;
      x_in = v[2:0];
      a_in = v[3] ^ v[4];
      rst  = (n >= 2000 && n < 2003);
      advance();
      @(negedge clk);
      compare();
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_miss++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
      $finish;
    end
  end
endmodule